// File: doc/BRIEF.md
# Triggered FADC Charge Integrator

This block extracts the charge of drift-chamber pulses from flash ADC samples, several channels at once. Every clock cycle each channel delivers one new 10-bit sample, which enters a per-channel history line. The level-1 trigger comes a fixed number of samples (`LATENCY`) after the collision. For every channel, the block then reads one pedestal sample just before the collision sample and the sum of a fixed window of `WINDOW` samples that starts at the collision sample. It subtracts `WINDOW` times the pedestal and clamps negative results to zero. With the default values (128 samples of latency and a 40-sample window at a 40 MHz sample rate), this is a 1 µs integral seen from 3.2 µs later.

A trigger is turned into a record in a single cycle. The record holds all channel charges, a hit mask and an 8-bit trigger tag, and it goes into a small record queue. A channel hits when its charge is above the programmable threshold. An output stage walks the hit channels of the oldest record in ascending channel order and sends one word per hit channel over a valid/ready handshake. Channels without a hit send nothing. Triggers may come on consecutive cycles. If a trigger finds the queue full, it is dropped and a sticky flag is raised.

Top module: `fadcChargeExtractor`

## Requirements
- R1: After reset `outValid` and `overflow` are 0, and the first trigger after reset carries tag 0.
- R2: Samples are numbered by the clock edge that captures them. For a trigger captured at edge T, the window is the samples from edges T-LATENCY through T-LATENCY+WINDOW-1. The pedestal is the sample from edge T-LATENCY-1. The charge is the window sum minus WINDOW times the pedestal.
- R3: A charge whose corrected value would be negative is reported as 0. A charge above the range of `outCharge` is reported as all ones.
- R4: A channel produces a word only if its charge is strictly greater than `threshold`. The words of one trigger leave in ascending channel order. A trigger with no hit channel produces no word.
- R5: `outTag` is the number of triggers seen since reset, modulo 256, counted before that trigger. Dropped triggers are counted as well.
- R6: A trigger is accepted on every cycle, including consecutive cycles, as long as the record queue is not full. No integration blocks a later trigger.
- R7: While `outValid` is 1 and `outReady` is 0, `outValid`, `outChannel`, `outCharge` and `outTag` stay unchanged on the next cycle.
- R8: A trigger that arrives while the queue holds `FIFO_DEPTH` records is dropped and sets `overflow`. `overflow` stays 1 until reset, and the records already queued are delivered unchanged.
- R9: Each channel is computed only from its own samples, at bits [c*SAMPLE_W +: SAMPLE_W] of `sampleIn`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; one sample per channel per rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleIn | input | NUM_CH*SAMPLE_W | Packed samples, channel c at bits c*SAMPLE_W |
| threshold | input | CHARGE_W | Zero-suppression threshold (strictly greater passes) |
| trigIn | input | 1 | Level-1 trigger strobe, one cycle per trigger |
| outReady | input | 1 | Consumer ready |
| outValid | output | 1 | Output word valid |
| outChannel | output | CH_W | Channel number of the word |
| outTag | output | TAG_W | Trigger tag of the word |
| outCharge | output | CHARGE_W | Pedestal-corrected charge |
| overflow | output | 1 | Sticky flag: a trigger was dropped because the queue was full |

## Verification
The assertions check four things on every cycle:
- A word waiting under back-pressure is held steady.
- The drop flag never clears without a reset.
- The drop flag rises only on a cycle that carried a trigger.
- No word with zero charge ever leaves.

The cycle-exact placement of the window and the pedestal, the scaling of the pedestal, clamping at zero, ascending channel order, suppression of hit-free triggers and tag counting across dropped triggers all depend on knowing the sample history. Only the bench scenarios, which record every sample they drive, can show these.

// File: rtl/fadcPkg.sv
`timescale 1ns/1ps
package fadcPkg;

  // Strobes from the control path to the datapath record queue
  typedef struct packed {
    logic push;
    logic pop;
  } fifoCtrl_t;

endpackage

// File: rtl/fadcDatapath.sv
`timescale 1ns/1ps
module fadcDatapath
  import fadcPkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int SAMPLE_W   = 10,
  parameter int LATENCY    = 128,
  parameter int WINDOW     = 40,
  parameter int CHARGE_W   = 16,
  parameter int TAG_W      = 8,
  parameter int FIFO_DEPTH = 4,
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int PTR_W     = $clog2(FIFO_DEPTH)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_CH*SAMPLE_W-1:0]   sampleIn,
  input  logic [CHARGE_W-1:0]          threshold,
  input  logic [TAG_W-1:0]             trigTag,
  input  fifoCtrl_t                    ctrl,
  input  logic [CH_W-1:0]              selChannel,
  output logic [NUM_CH-1:0]            headHits,
  output logic [CHARGE_W-1:0]          headCharge,
  output logic [TAG_W-1:0]             headTag
);

  localparam int HIST  = LATENCY + 1;                 // window history plus pedestal slot
  localparam int SUM_W = SAMPLE_W + $clog2(WINDOW + 1);
  localparam int WIDE  = (SUM_W > CHARGE_W) ? SUM_W : CHARGE_W;
  localparam int MAX_Q = (2 ** CHARGE_W) - 1;

  logic [NUM_CH-1:0][CHARGE_W-1:0] chargeNow;
  logic [NUM_CH-1:0]               hitNow;

  for (genvar c = 0; c < NUM_CH; c++) begin : gChan
    logic [SAMPLE_W-1:0] hist [HIST];
    logic [SUM_W-1:0]    winSum;
    logic [SUM_W-1:0]    pedScaled;
    logic [SUM_W-1:0]    netSum;
    logic [WIDE-1:0]     netWide;
    logic [CHARGE_W-1:0] qLocal;

    // hist[k] holds the sample captured k+1 edges ago; winSum tracks hist[LATENCY-WINDOW .. LATENCY-1]
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        winSum <= '0;
        for (int k = 0; k < HIST; k++) hist[k] <= '0;
      end else begin
        hist[0] <= sampleIn[c*SAMPLE_W +: SAMPLE_W];
        for (int k = 1; k < HIST; k++) hist[k] <= hist[k-1];
        winSum <= winSum + SUM_W'(hist[LATENCY-WINDOW-1]) - SUM_W'(hist[LATENCY-1]);
      end
    end

    always_comb begin
      pedScaled = SUM_W'(hist[LATENCY]) * SUM_W'(WINDOW);
      netSum    = (winSum > pedScaled) ? (winSum - pedScaled) : '0;
      netWide   = WIDE'(netSum);
      qLocal    = (netWide > WIDE'(MAX_Q)) ? '1 : CHARGE_W'(netWide);
    end

    assign chargeNow[c] = qLocal;
    assign hitNow[c]    = (qLocal > threshold);
  end

  // Record queue: one entry per accepted trigger
  logic [NUM_CH-1:0][CHARGE_W-1:0] memQ    [FIFO_DEPTH];
  logic [NUM_CH-1:0]               memHits [FIFO_DEPTH];
  logic [TAG_W-1:0]                memTag  [FIFO_DEPTH];
  logic [PTR_W-1:0]                wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(FIFO_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (ctrl.push) wrPtr <= nextPtr(wrPtr);
      if (ctrl.pop)  rdPtr <= nextPtr(rdPtr);
    end
  end

  always_ff @(posedge clk) begin
    if (ctrl.push) begin
      memQ[wrPtr]    <= chargeNow;
      memHits[wrPtr] <= hitNow;
      memTag[wrPtr]  <= trigTag;
    end
  end

  assign headHits   = memHits[rdPtr];
  assign headCharge = memQ[rdPtr][selChannel];
  assign headTag    = memTag[rdPtr];

endmodule

// File: rtl/fadcControl.sv
`timescale 1ns/1ps
module fadcControl
  import fadcPkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int TAG_W      = 8,
  parameter int FIFO_DEPTH = 4,
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trigIn,
  input  logic              outReady,
  input  logic [NUM_CH-1:0] headHits,
  output fifoCtrl_t         ctrl,
  output logic [TAG_W-1:0]  trigTag,
  output logic [CH_W-1:0]   selChannel,
  output logic              outValid,
  output logic              overflow
);

  logic [CNT_W-1:0]  fill;
  logic [NUM_CH-1:0] served, pending, selOne;
  logic              empty, full, lastOne;
  logic [TAG_W-1:0]  tagCnt;

  always_comb begin
    empty      = (fill == '0);
    full       = (fill == CNT_W'(FIFO_DEPTH));
    pending    = headHits & ~served;
    selChannel = '0;
    selOne     = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pending[i]) begin
        selChannel = CH_W'(i);
        selOne     = NUM_CH'(1) << i;
      end
    end
    lastOne   = ((pending & ~selOne) == '0);
    outValid  = !empty && (pending != '0);
    ctrl.push = trigIn && !full;
    ctrl.pop  = !empty && ((pending == '0) || (outReady && lastOne));
  end

  assign trigTag = tagCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fill     <= '0;
      served   <= '0;
      tagCnt   <= '0;
      overflow <= 1'b0;
    end else begin
      case ({ctrl.push, ctrl.pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
      if (ctrl.pop)                  served <= '0;
      else if (outValid && outReady) served <= served | selOne;
      if (trigIn)                    tagCnt <= tagCnt + 1'b1;
      if (trigIn && full)            overflow <= 1'b1;
    end
  end

endmodule

// File: rtl/fadcChargeExtractor.sv
`timescale 1ns/1ps
module fadcChargeExtractor
  import fadcPkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int SAMPLE_W   = 10,
  parameter int LATENCY    = 128,
  parameter int WINDOW     = 40,
  parameter int CHARGE_W   = 16,
  parameter int TAG_W      = 8,
  parameter int FIFO_DEPTH = 4,
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_CH*SAMPLE_W-1:0] sampleIn,
  input  logic [CHARGE_W-1:0]        threshold,
  input  logic                       trigIn,
  input  logic                       outReady,
  output logic                       outValid,
  output logic [CH_W-1:0]            outChannel,
  output logic [TAG_W-1:0]           outTag,
  output logic [CHARGE_W-1:0]        outCharge,
  output logic                       overflow
);

  fifoCtrl_t         ctrl;
  logic [TAG_W-1:0]  trigTag;
  logic [NUM_CH-1:0] headHits;

  fadcControl #(
    .NUM_CH(NUM_CH), .TAG_W(TAG_W), .FIFO_DEPTH(FIFO_DEPTH)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .outReady(outReady),
    .headHits(headHits), .ctrl(ctrl), .trigTag(trigTag),
    .selChannel(outChannel), .outValid(outValid), .overflow(overflow)
  );

  fadcDatapath #(
    .NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .LATENCY(LATENCY), .WINDOW(WINDOW),
    .CHARGE_W(CHARGE_W), .TAG_W(TAG_W), .FIFO_DEPTH(FIFO_DEPTH)
  ) uData (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .threshold(threshold),
    .trigTag(trigTag), .ctrl(ctrl), .selChannel(outChannel),
    .headHits(headHits), .headCharge(outCharge), .headTag(outTag)
  );

endmodule

// File: rtl/fadcChargeExtractorChecker.sv
`timescale 1ns/1ps
module fadcChargeExtractorChecker #(
  parameter int CH_W     = 2,
  parameter int CHARGE_W = 16,
  parameter int TAG_W    = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                trigIn,
  input logic                outReady,
  input logic                outValid,
  input logic [CH_W-1:0]     outChannel,
  input logic [TAG_W-1:0]    outTag,
  input logic [CHARGE_W-1:0] outCharge,
  input logic                overflow
);

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outChannel) && $stable(outCharge) && $stable(outTag))); // R7

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow); // R8

  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> $past(trigIn)); // R8

  AST_NONZERO_WORD: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outCharge != '0)); // R4

endmodule

bind fadcChargeExtractor fadcChargeExtractorChecker #(
  .CH_W(CH_W), .CHARGE_W(CHARGE_W), .TAG_W(TAG_W)
) uChk (
  .clk(clk), .rstN(rstN), .trigIn(trigIn), .outReady(outReady),
  .outValid(outValid), .outChannel(outChannel), .outTag(outTag),
  .outCharge(outCharge), .overflow(overflow)
);

// File: tb/fadcChargeExtractor_test.sv
`timescale 1ns/1ps
module fadcChargeExtractor_test;

  localparam int NUM_CH = 4, SAMPLE_W = 10, LATENCY = 128, WINDOW = 40;
  localparam int CHARGE_W = 16, TAG_W = 8, FIFO_DEPTH = 4, CH_W = 2;
  localparam int REC_N = 8192;
  localparam int NVEC = 5;
  // columns: ped, len, thr, amp0..amp3, q0..q3
  localparam int VEC [NVEC][11] = '{
    '{50,   20, 100, 0,  10, 100, 3, 0,   200, 2000, 60},
    '{0,    40, 199, 20, 0,  0,   5, 800, 0,   0,    200},
    '{300,  5,  0,   1,  2,  3,   4, 5,   10,  15,   20},
    '{1000, 40, 0,   23, 0,  0,   0, 920, 0,   0,    0},
    '{200,  10, 500, 5,  5,  5,   5, 50,  50,  50,   50}
  };

  logic clk = 0, rstN = 0, trigIn = 0, outReady = 1;
  logic [NUM_CH*SAMPLE_W-1:0] sampleIn = '0;
  logic [CHARGE_W-1:0] threshold = '0;
  logic outValid, overflow;
  logic [CH_W-1:0] outChannel;
  logic [TAG_W-1:0] outTag;
  logic [CHARGE_W-1:0] outCharge;

  fadcChargeExtractor uut (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .threshold(threshold),
    .trigIn(trigIn), .outReady(outReady), .outValid(outValid),
    .outChannel(outChannel), .outTag(outTag), .outCharge(outCharge),
    .overflow(overflow)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, expTag = 0;
  bit done = 0;
  int rec [REC_N][NUM_CH];
  int pPed = 0, pLen = 0, pC = 1 << 30, pSlope = 0;
  int pAmp [NUM_CH] = '{0, 0, 0, 0};
  int eCh[$], eQ[$], eTag[$];
  int trigAt[8];

  always @(posedge clk) begin
    if (!rstN) cyc <= 0;
    else       cyc <= cyc + 1;
  end

  // sample driver: sample for edge index cyc, recorded for the model
  always @(negedge clk) begin
    for (int c = 0; c < NUM_CH; c++) begin
      int v;
      v = pPed;
      if (cyc >= pC && cyc < pC + pLen)
        v = v + pAmp[c] + ((c == 0) ? pSlope * (cyc - pC) : 0);
      if (v < 0) v = 0;
      if (v > 1023) v = 1023;
      sampleIn[c*SAMPLE_W +: SAMPLE_W] = SAMPLE_W'(v);
      if (cyc < REC_N) rec[cyc][c] = v;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic setPattern(input int ped, input int len, input int a0, input int a1,
                            input int a2, input int a3, input int slope);
    pPed = ped; pLen = len; pSlope = slope;
    pAmp[0] = a0; pAmp[1] = a1; pAmp[2] = a2; pAmp[3] = a3;
    pC = cyc + 3;
  endtask

  // fire n back-to-back triggers, the first captured at edge t
  task automatic fireAt(input int t, input int n);
    while (cyc < t) tick();
    trigIn = 1;
    for (int k = 0; k < n; k++) begin
      trigAt[k] = cyc;
      tick();
    end
    trigIn = 0;
  endtask

  function automatic int modelQ(input int t, input int c);
    int s = 0;
    for (int i = 0; i < WINDOW; i++) s += rec[t - LATENCY + i][c];
    s -= WINDOW * rec[t - LATENCY - 1][c];
    if (s < 0) s = 0;
    if (s > 65535) s = 65535;
    return s;
  endfunction

  task automatic expectWord(input int ch, input int q, input int tag);
    eCh.push_back(ch); eQ.push_back(q); eTag.push_back(tag);
  endtask

  task automatic collect(input int cycles, input string req);
    outReady = 1;
    for (int n = 0; n < cycles; n++) begin
      @(negedge clk);
      if (outValid) begin
        if (eCh.size() == 0) begin
          check(0, req, "unexpected word on channel", int'(outChannel), -1);
        end else begin
          check(int'(outChannel) == eCh[0], req, "channel", int'(outChannel), eCh[0]);
          check(int'(outCharge) == eQ[0], req, "charge", int'(outCharge), eQ[0]);
          check(int'(outTag) == (eTag[0] % 256), req, "tag", int'(outTag), eTag[0] % 256);
          void'(eCh.pop_front()); void'(eQ.pop_front()); void'(eTag.pop_front());
        end
      end
    end
    check(eCh.size() == 0, req, "words missing", eCh.size(), 0);
    eCh.delete(); eQ.delete(); eTag.delete();
    tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1;
    // R1: reset state
    @(negedge clk);
    check(outValid == 0, "R1", "outValid after reset", int'(outValid), 0);
    check(overflow == 0, "R1", "overflow after reset", int'(overflow), 0);
    tick();

    // R2 R4 R9: table of patterns, expected charges per channel
    for (int v = 0; v < NVEC; v++) begin
      threshold = CHARGE_W'(VEC[v][2]);
      setPattern(VEC[v][0], VEC[v][1], VEC[v][3], VEC[v][4], VEC[v][5], VEC[v][6], 0);
      fireAt(pC + LATENCY, 1);
      for (int c = 0; c < NUM_CH; c++)
        if (VEC[v][7+c] > VEC[v][2]) expectWord(c, VEC[v][7+c], expTag); // R5 tag, first is 0 (R1)
      expTag++;
      collect(20, "R2 R4 R9");
    end

    // R3: negative corrected charge clamps to zero and is suppressed
    threshold = '0;
    setPattern(500, 10, -100, -500, 0, 7, 0);
    fireAt(pC + LATENCY, 1);
    expectWord(3, 70, expTag);
    expTag++;
    collect(20, "R3");

    // R6 R8: back-to-back triggers with queue stalled; fifth is dropped
    outReady = 0;
    setPattern(100, 40, 0, 0, 0, 0, 5);
    fireAt(pC + LATENCY, FIFO_DEPTH + 1);
    @(negedge clk);
    check(overflow == 1, "R8", "overflow after drop", int'(overflow), 1);
    check(outValid == 1, "R6", "word pending after burst", int'(outValid), 1);
    for (int k = 0; k < FIFO_DEPTH; k++)
      for (int c = 0; c < NUM_CH; c++)
        if (modelQ(trigAt[k], c) > 0) expectWord(c, modelQ(trigAt[k], c), expTag + k);
    expTag += FIFO_DEPTH + 1;
    check(eCh.size() == FIFO_DEPTH, "R6", "model words in burst", eCh.size(), FIFO_DEPTH);
    tick();
    collect(30, "R6 R8");
    check(overflow == 1, "R8", "overflow sticky after drain", int'(overflow), 1);

    // R5: tag after a dropped trigger still counts it
    setPattern(0, 40, 20, 0, 0, 0, 0);
    fireAt(pC + LATENCY, 1);
    expectWord(0, 800, expTag);
    expTag++;
    collect(20, "R5");

    // R7: back-pressure holds the word
    outReady = 0;
    setPattern(10, 10, 1, 2, 0, 4, 0);
    fireAt(pC + LATENCY, 1);
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      check(outValid == 1 && outChannel == 0 && outCharge == 10, "R7", "held word charge",
            int'(outCharge), 10);
    end
    tick();
    expectWord(0, 10, expTag);
    expectWord(1, 20, expTag);
    expectWord(3, 40, expTag);
    expTag++;
    collect(20, "R7 R4");

    // R1: reset clears the sticky flag
    rstN = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(overflow == 0, "R1", "overflow cleared by reset", int'(overflow), 0);
    check(outValid == 0, "R1", "outValid cleared by reset", int'(outValid), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule